// File: doc/BRIEF.md
# Serial Cartridge Bank Latch

This block holds the bank mask of a flash cartridge. Software has no direct path to the mask. It bit-banks a serial word through three bits of a general-purpose output port: a shift clock, a data bit and a chip select. Every write to that port reaches the block as a one-cycle strobe carrying the new 8-bit port value. The block keeps the value from the previous write and compares the two. A rising shift clock moves one data bit into an internal shifter. A rising chip select transfers the shifter into the bank mask.

Each port write is decoded into exactly one of three actions, carried as an enumerated state:
- `ACT_HOLD`: no edge of interest.
- `ACT_SHIFT`: the shift clock rose.
- `ACT_LATCH`: chip select rose and the shift clock did not.

The transitions are fixed per write. Any write moves from the idle decode to one of these three. A cycle with no write is always `ACT_HOLD`.

Bit 7 of the mask decides whether save memory is mapped. When a latch changes that bit, the block pulses `save_req` for one cycle so that the save logic can act. One cartridge variant always has its save memory mapped. For that variant a parameter forces mask bit 7 high on every latch.

Top module: `cart_bank_latch`

## Requirements
- R1: After reset, `bank_mask` is 0x00 and `save_req` is 0. The shifter and the stored previous port value are both zero, so a latch with no preceding shifts gives mask 0x00 (0x80 when the force option is set).
- R2: A port bit counts as rising only when it is 1 in the new write and 0 in the previous write. A bit that stays high, or that falls, causes no action. Default bit positions are shift clock = bit 0, data = bit 1 and chip select = bit 2.
- R3: On a shift-clock rise the shifter moves left by one place. Its bit 0 takes the data bit of the previous port write, not of the current one.
- R4: When the shift clock and chip select rise in the same write, only the shift happens and `bank_mask` keeps its value.
- R5: On a chip-select rise without a shift-clock rise, the shifter is copied into `bank_mask`, which changes in the cycle after the write.
- R6: `save_req` is high for exactly the one cycle after a latch whose new mask differs from the old one in bit 7. Otherwise it is 0.
- R7: With `FORCE_SAVE_BIT` = 1, every latch sets `bank_mask` bit 7 to 1 whatever the shifter holds.
- R8: In cycles without `port_we`, the shifter, mask and stored previous port value do not change, whatever is on `port_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_we | input | 1 | One-cycle strobe: the port was written |
| port_wdata | input | 8 | New port output value |
| bank_mask | output | 8 | Latched bank mask |
| save_req | output | 1 | One-cycle pulse when mask bit 7 changes |

## Verification
The assertions rely on port writes being discrete events marked by `port_we`. Chip select must return low through a separate write before it can rise again. Under that rule, two latches that both change bit 7 can never fall in adjacent cycles. The stimulus keeps to this rule by construction, because every edge is a distinct write. Random port bytes are mixed with idle cycles that carry garbage on `port_wdata`. Directed serial words cover the bit-7 transitions, the priority case and the forced-bit variant.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LATCH = 2'd2
    } cbl_act_e;

endpackage

// File: rtl/cbl_edge_decode.sv
module cbl_edge_decode
    import cbl_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int CLK_BIT  = 0,
    parameter int MOSI_BIT = 1,
    parameter int CS_BIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_we,
    input  logic [PORT_W-1:0] port_wdata,
    output logic              prev_mosi,
    output cbl_act_e          act
);

    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] rise;

    // Previous port value, advanced only by port writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (port_we) begin
            prev_q <= port_wdata;
        end
    end

    assign rise      = port_wdata & ~prev_q;
    assign prev_mosi = prev_q[MOSI_BIT];

    // Shift clock has priority over chip select
    always_comb begin
        act = ACT_HOLD;
        if (port_we) begin
            if (rise[CLK_BIT]) begin
                act = ACT_SHIFT;
            end else if (rise[CS_BIT]) begin
                act = ACT_LATCH;
            end
        end
    end

    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !port_we |=> $stable(prev_q)); // R8

    AST_NO_ACT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !port_we |-> act == ACT_HOLD); // R8

endmodule

// File: rtl/cbl_shift_latch.sv
module cbl_shift_latch
    import cbl_pkg::*;
#(
    parameter int MASK_W         = 8,
    parameter bit FORCE_SAVE_BIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cbl_act_e          act,
    input  logic              prev_mosi,
    output logic [MASK_W-1:0] bank_mask,
    output logic              save_req
);

    localparam int MSB = MASK_W - 1;
    localparam logic [MASK_W-1:0] TOP_ONE = {1'b1, {(MASK_W-1){1'b0}}};

    logic [MASK_W-1:0] shift_q;
    logic [MASK_W-1:0] mask_q;
    logic              save_q;
    logic [MASK_W-1:0] latch_val;

    assign latch_val = FORCE_SAVE_BIT ? (shift_q | TOP_ONE) : shift_q;

    // State register: shifter and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            mask_q  <= '0;
        end else begin
            unique case (act)
                ACT_SHIFT: shift_q <= {shift_q[MSB-1:0], prev_mosi};
                ACT_LATCH: mask_q  <= latch_val;
                default: ;
            endcase
        end
    end

    // Output process: save strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_LATCH: save_q <= latch_val[MSB] ^ mask_q[MSB];
                default:   save_q <= 1'b0;
            endcase
        end
    end

    assign bank_mask = mask_q;
    assign save_req  = save_q;

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_SHIFT |=> shift_q[0] == $past(prev_mosi)); // R3

    AST_SHIFT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_SHIFT |=> $stable(mask_q)); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_HOLD |=> $stable(mask_q) && $stable(shift_q)); // R8

    AST_SAVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        save_q |=> !save_q); // R6

    AST_SAVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        save_q |-> mask_q[MSB] != $past(mask_q[MSB])); // R6

    AST_FORCE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (FORCE_SAVE_BIT && act == ACT_LATCH) |=> mask_q[MSB]); // R7

endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
    import cbl_pkg::*;
#(
    parameter int PORT_W         = 8,
    parameter int MASK_W         = 8,
    parameter int CLK_BIT        = 0,
    parameter int MOSI_BIT       = 1,
    parameter int CS_BIT         = 2,
    parameter bit FORCE_SAVE_BIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_we,
    input  logic [PORT_W-1:0] port_wdata,
    output logic [MASK_W-1:0] bank_mask,
    output logic              save_req
);

    cbl_act_e act;
    logic     prev_mosi;

    cbl_edge_decode #(
        .PORT_W  (PORT_W),
        .CLK_BIT (CLK_BIT),
        .MOSI_BIT(MOSI_BIT),
        .CS_BIT  (CS_BIT)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_we   (port_we),
        .port_wdata(port_wdata),
        .prev_mosi (prev_mosi),
        .act       (act)
    );

    cbl_shift_latch #(
        .MASK_W        (MASK_W),
        .FORCE_SAVE_BIT(FORCE_SAVE_BIT)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .prev_mosi(prev_mosi),
        .bank_mask(bank_mask),
        .save_req (save_req)
    );

    AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !port_we |=> $stable(bank_mask) && !save_req); // R8

endmodule

// File: tb/cart_bank_latch_tb.sv
module cart_bank_latch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_we = 1'b0;
    logic [7:0] port_wdata = 8'h00;
    logic [7:0] mask_a, mask_b;
    logic       save_a, save_b;

    int n_tests = 0;
    int n_fail  = 0;

    // model state: index 0 = plain, 1 = forced bit 7
    logic [7:0] m_prev;
    logic [7:0] m_shift;
    logic [7:0] m_mask [2];
    logic       m_save [2];

    always #10 clk = ~clk;

    cart_bank_latch #(.FORCE_SAVE_BIT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .port_we(port_we), .port_wdata(port_wdata),
        .bank_mask(mask_a), .save_req(save_a)
    );

    cart_bank_latch #(.FORCE_SAVE_BIT(1'b1)) u_dut_force (
        .clk(clk), .rst_n(rst_n), .port_we(port_we), .port_wdata(port_wdata),
        .bank_mask(mask_b), .save_req(save_b)
    );

    function automatic logic f_rise(input logic [7:0] nv, input logic [7:0] ov, input int b);
        return nv[b] & ~ov[b];
    endfunction

    function automatic logic [7:0] f_latch_val(input logic [7:0] sh, input bit force_top);
        return force_top ? (sh | 8'h80) : sh;
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "mask", mask_a, m_mask[0]);
        check(req, "save", {7'd0, save_a}, {7'd0, m_save[0]});
        check(req, "mask(force)", mask_b, m_mask[1]);
        check(req, "save(force)", {7'd0, save_b}, {7'd0, m_save[1]});
    endtask

    task automatic wr(input logic [7:0] v, input string req);
        @(negedge clk);
        port_we = 1'b1;
        port_wdata = v;
        m_save[0] = 1'b0;
        m_save[1] = 1'b0;
        if (f_rise(v, m_prev, 0)) begin
            m_shift = {m_shift[6:0], m_prev[1]};
        end else if (f_rise(v, m_prev, 2)) begin
            for (int k = 0; k < 2; k++) begin
                logic [7:0] nv;
                nv = f_latch_val(m_shift, k == 1);
                m_save[k] = nv[7] ^ m_mask[k][7];
                m_mask[k] = nv;
            end
        end
        m_prev = v;
        @(negedge clk);
        port_we = 1'b0;
        check_all(req);
    endtask

    task automatic idle(input logic [7:0] junk);
        @(negedge clk);
        port_we = 1'b0;
        port_wdata = junk;
        m_save[0] = 1'b0;
        m_save[1] = 1'b0;
        @(negedge clk);
        check_all("R8");
    endtask

    // serial word, MSB first: data set with clock low, then clock rises
    task automatic send_word(input logic [7:0] w, input string req);
        for (int i = 7; i >= 0; i--) begin
            wr({6'd0, w[i], 1'b0}, req);
            wr({6'd0, w[i], 1'b1}, req);
        end
        wr(8'h00, req);
        wr(8'h04, req);
        wr(8'h00, req);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        m_prev = 0; m_shift = 0;
        m_mask[0] = 0; m_mask[1] = 0; m_save[0] = 0; m_save[1] = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        // latch straight after reset: shifter still zero
        wr(8'h04, "R1");
        wr(8'h00, "R1");
        // R5 / R6: bit 7 rises, falls, stays low
        send_word(8'hA5, "R5");
        send_word(8'h25, "R6");
        send_word(8'h3C, "R6");
        send_word(8'hC3, "R3");
        // R4: clock and chip select rise together
        wr(8'h00, "R4");
        wr(8'h05, "R4");
        wr(8'h00, "R4");
        // R2: held-high bits cause nothing; falling bits cause nothing
        wr(8'h07, "R2");
        wr(8'h07, "R2");
        wr(8'h02, "R2");
        wr(8'h03, "R2");
        wr(8'h07, "R2");
        wr(8'h04, "R7");
        // R8: idle cycles with edges on the data bus
        idle(8'h05);
        idle(8'hFF);
        wr(8'h00, "R8");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if ($urandom % 4 == 0) idle(r);
            else wr(r, "R3");
        end
        send_word(8'h80, "R7");
        send_word(8'h00, "R6");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule